// File: doc/BRIEF.md
# Rotating Segment Animator

This block drives a single common-cathode seven-segment digit so that one lit outer segment appears to move around the digit. A tick divider derives the step rate from the system clock. Each tick moves the lit segment one place, clockwise or counterclockwise, as chosen by a direction level. A speed level selects a full or a halved step period. The direction and speed levels may both change while the animation runs, and each change applies from the next step.

A rising edge on the start/stop input starts the animation from idle. A second rising edge asks it to stop. The stop is deferred: the segment keeps moving until it lands back on the top segment, and only then does the block return to idle. A counter records how many times the lit segment arrives on the top segment while the animation runs.

The controller has three states. IDLE holds the top segment lit. RUN steps the segment on every tick. DRAIN steps like RUN while a stop is pending. The transitions are:
- IDLE→RUN on a start/stop edge.
- RUN→DRAIN on a start/stop edge when the same cycle's step, if any, does not land on the top segment.
- RUN→IDLE when a start/stop edge and a step onto the top segment occur in the same cycle.
- DRAIN→IDLE on a step that lands on the top segment.

Top module: `seg_spinner`

## Requirements
- R1: A synchronous active-high `rst` forces IDLE, lights only segment a (`seg` = 7'b0000001), clears `rotations` and restarts the tick divider.
- R2: `seg` bit 0 is segment a, bit 1 is b, up to bit 5 for f, and bit 6 is g. With `dir_cw` = 1, each step moves the lit segment a→b→c→d→e→f→a.
- R3: With `dir_cw` = 0, each step moves the lit segment in the reverse order, a→f→e→d→c→b→a.
- R4: While running, a step happens every `TICK_SLOW` clock cycles when `speed_fast` = 0, and every `TICK_SLOW/2` cycles when `speed_fast` = 1. The first step comes `TICK_SLOW` (or `TICK_SLOW/2`) cycles after the start edge.
- R5: In IDLE the display does not move. After a start edge the animation repeats without end until a stop edge arrives.
- R6: After a stop edge, the segment keeps stepping until it lands on segment a. The block then enters IDLE with segment a lit.
- R7: `start_stop` is edge-detected, so a press held for any number of cycles counts as a single event.
- R8: `rotations` increases by one each time a step lands the lit segment on segment a while the block runs. It changes at no other time.
- R9: Exactly one of segments a–f is lit at all times, and segment g is never lit.
- R10: A change of `dir_cw` or `speed_fast` while running applies from the next step, without stopping the animation.
- R11: A start/stop edge in DRAIN is ignored. The block neither resumes RUN nor abandons the pending stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_cw | input | 1 | 1: clockwise, 0: counterclockwise |
| start_stop | input | 1 | Start/stop request level, edge-detected |
| speed_fast | input | 1 | 0: full step period, 1: half step period |
| seg | output | 7 | Segment lines, active high, bit 0 = a … bit 6 = g |
| rotations | output | ROT_W (16) | Count of arrivals on segment a while running |

## Verification
The assertions assume that all inputs are synchronous and held steady across each clock edge. They also assume that reset is held for at least one full cycle before it is released. The bench meets both conditions by changing inputs only on the falling clock edge and by holding reset for four cycles at the start. The properties also assume that the tick divider is at least two cycles long, so a step never occurs in the same cycle as the start edge. The bench therefore runs a divider of eight cycles, which gives four cycles at the fast speed.

// File: rtl/spin_pkg.sv
package spin_pkg;

    localparam int NUM_POS = 6;
    localparam int POS_W   = 3;
    localparam int SEG_W   = 7;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } spin_state_e;

    typedef logic [POS_W-1:0] pos_t;

    localparam pos_t POS_HOME = pos_t'(0);
    localparam pos_t POS_LAST = pos_t'(NUM_POS - 1);

endpackage

// File: rtl/spin_pulse_det.sv
module spin_pulse_det (
    input  logic clk,
    input  logic rst,
    input  logic level_i,
    output logic pulse_o
);
    logic level_q;

    always_ff @(posedge clk) begin
        if (rst) level_q <= 1'b0;
        else     level_q <= level_i;
    end

    assign pulse_o = level_i & ~level_q;
endmodule

// File: rtl/spin_tick_gen.sv
module spin_tick_gen #(
    parameter int TICK_SLOW = 10_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic enable_i,
    input  logic fast_i,
    output logic tick_o
);
    localparam int CNT_W     = $clog2(TICK_SLOW + 1);
    localparam int TICK_FAST = (TICK_SLOW / 2 < 1) ? 1 : TICK_SLOW / 2;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit_m1;

    always_comb begin
        if (fast_i) limit_m1 = CNT_W'(TICK_FAST - 1);
        else        limit_m1 = CNT_W'(TICK_SLOW - 1);
    end

    assign tick_o = enable_i && (cnt_q >= limit_m1);

    always_ff @(posedge clk) begin
        if (rst || !enable_i) cnt_q <= '0;
        else if (tick_o)      cnt_q <= '0;
        else                  cnt_q <= cnt_q + CNT_W'(1);
    end
endmodule

// File: rtl/spin_fsm.sv
module spin_fsm
    import spin_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_i,
    input  logic        tick_i,
    input  logic        dir_cw_i,
    output spin_state_e state_o,
    output pos_t        pos_o,
    output logic        wrap_o
);
    spin_state_e state_q, state_d;
    pos_t        pos_q, pos_d, step_pos;
    logic        stop_want;

    always_comb begin
        if (dir_cw_i) step_pos = (pos_q == POS_LAST) ? POS_HOME : pos_q + pos_t'(1);
        else          step_pos = (pos_q == POS_HOME) ? POS_LAST : pos_q - pos_t'(1);
    end

    always_comb begin
        state_d   = state_q;
        pos_d     = pos_q;
        wrap_o    = 1'b0;
        stop_want = (state_q == ST_DRAIN) || req_i;
        unique case (state_q)
            ST_IDLE: begin
                pos_d = POS_HOME;
                if (req_i) state_d = ST_RUN;
            end
            ST_RUN, ST_DRAIN: begin
                if (tick_i) begin
                    pos_d  = step_pos;
                    wrap_o = (step_pos == POS_HOME);
                end
                if (stop_want) begin
                    if (tick_i && step_pos == POS_HOME) state_d = ST_IDLE;
                    else                                state_d = ST_DRAIN;
                end
            end
            default: begin
                state_d = ST_IDLE;
                pos_d   = POS_HOME;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            pos_q   <= POS_HOME;
        end else begin
            state_q <= state_d;
            pos_q   <= pos_d;
        end
    end

    assign state_o = state_q;
    assign pos_o   = pos_q;
endmodule

// File: rtl/spin_rot_counter.sv
module spin_rot_counter #(
    parameter int ROT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc_i,
    output logic [ROT_W-1:0] count_o
);
    always_ff @(posedge clk) begin
        if (rst)        count_o <= '0;
        else if (inc_i) count_o <= count_o + ROT_W'(1);
    end
endmodule

// File: rtl/seg_spinner.sv
module seg_spinner
    import spin_pkg::*;
#(
    parameter int TICK_SLOW = 10_000_000,
    parameter int ROT_W     = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dir_cw,
    input  logic             start_stop,
    input  logic             speed_fast,
    output logic [6:0]       seg,
    output logic [ROT_W-1:0] rotations
);
    logic        req;
    logic        tick;
    logic        wrap;
    spin_state_e state_q;
    pos_t        pos;

    spin_pulse_det u_req (
        .clk     (clk),
        .rst     (rst),
        .level_i (start_stop),
        .pulse_o (req)
    );

    spin_tick_gen #(.TICK_SLOW(TICK_SLOW)) u_tick (
        .clk      (clk),
        .rst      (rst),
        .enable_i (state_q != ST_IDLE),
        .fast_i   (speed_fast),
        .tick_o   (tick)
    );

    spin_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .req_i    (req),
        .tick_i   (tick),
        .dir_cw_i (dir_cw),
        .state_o  (state_q),
        .pos_o    (pos),
        .wrap_o   (wrap)
    );

    spin_rot_counter #(.ROT_W(ROT_W)) u_rot (
        .clk     (clk),
        .rst     (rst),
        .inc_i   (wrap),
        .count_o (rotations)
    );

    always_comb begin
        seg = '0;
        for (int i = 0; i < NUM_POS; i++) begin
            if (pos == pos_t'(i)) seg[i] = 1'b1;
        end
    end
endmodule

// File: rtl/spin_checker.sv
module spin_checker
    import spin_pkg::*;
#(
    parameter int ROT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [6:0]       seg,
    input logic [ROT_W-1:0] rotations,
    input spin_state_e      state_q
);
    function automatic logic [5:0] ring_cw(input logic [5:0] r);
        return {r[4:0], r[5]};
    endfunction

    function automatic logic [5:0] ring_ccw(input logic [5:0] r);
        return {r[0], r[5:1]};
    endfunction

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (seg == 7'h01 && rotations == '0 && state_q == ST_IDLE));

    p_step_neighbour_r2: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && seg != $past(seg)) |->
        (seg[5:0] == ring_cw($past(seg[5:0])) || seg[5:0] == ring_ccw($past(seg[5:0]))));

    p_idle_frozen_r5: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(state_q) == ST_IDLE && state_q == ST_IDLE) |->
        ($stable(seg) && $stable(rotations)));

    p_drain_exit_home_r6: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(state_q) == ST_DRAIN && state_q == ST_IDLE) |-> seg == 7'h01);

    p_count_step_r8: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && rotations != $past(rotations)) |->
        (rotations == $past(rotations) + ROT_W'(1) && seg[0]));

    p_one_segment_r9: assert property (@(posedge clk) disable iff (rst)
        ($countones(seg[5:0]) == 1 && !seg[6]));

    p_drain_no_resume_r11: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(state_q) == ST_DRAIN) |-> state_q != ST_RUN);
endmodule

bind seg_spinner spin_checker #(.ROT_W(ROT_W)) u_spin_chk (
    .clk       (clk),
    .rst       (rst),
    .seg       (seg),
    .rotations (rotations),
    .state_q   (state_q)
);

// File: tb/seg_spinner_tb_top.sv
`timescale 1ns/1ps
module seg_spinner_tb_top;
    localparam int TICK = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dir_cw = 1'b1;
    logic        start_stop = 1'b0;
    logic        speed_fast = 1'b0;
    logic [6:0]  seg;
    logic [15:0] rotations;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    // behavioural reference
    int m_state = 0;   // 0 idle, 1 run, 2 draining
    int m_pos = 0;
    int m_phase = 0;
    int m_rot = 0;
    bit m_prev = 1'b0;

    always #2.5 clk = ~clk;

    seg_spinner #(.TICK_SLOW(TICK), .ROT_W(16)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .dir_cw     (dir_cw),
        .start_stop (start_stop),
        .speed_fast (speed_fast),
        .seg        (seg),
        .rotations  (rotations)
    );

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_sim();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_state = 0; m_pos = 0; m_phase = 0; m_rot = 0; m_prev = 1'b0;
        end else begin
            automatic bit pulse = start_stop && !m_prev;
            automatic int lim = speed_fast ? TICK / 2 : TICK;
            automatic bit tick = (m_state != 0) && (m_phase >= lim - 1);
            m_prev = start_stop;
            if (m_state == 0)  m_phase = 0;
            else if (tick)     m_phase = 0;
            else               m_phase++;
            if (m_state == 0) begin
                if (pulse) m_state = 1;
            end else begin
                automatic bit stop = (m_state == 2) || pulse;
                if (tick) begin
                    m_pos = dir_cw ? (m_pos + 1) % 6 : (m_pos + 5) % 6;
                    if (m_pos == 0) m_rot++;
                end
                if (stop) m_state = (tick && m_pos == 0) ? 0 : 2;
            end
        end
        if (cyc > 20000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            finish_sim();
        end
    end

    // every-cycle comparison against the reference
    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R2/R3/R9/R10 segments", int'(seg), 1 << m_pos);
            check("R8 rotations", int'(rotations), m_rot & 16'hFFFF);
        end
    end

    task automatic press(int n);
        start_stop = 1'b1;
        repeat (n) @(negedge clk);
        start_stop = 1'b0;
        @(negedge clk);
    endtask

    task automatic measure(output int n);
        logic [6:0] s0;
        int guard = 0;
        s0 = seg;
        while (seg == s0 && guard < 100) begin @(negedge clk); guard++; end
        s0 = seg;
        n = 0;
        do begin @(negedge clk); n++; end while (seg == s0 && n < 100);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 300 && m_state != 0; i++) @(negedge clk);
    endtask

    initial begin
        int n;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset seg", int'(seg), 1);
        check("R1 reset rotations", int'(rotations), 0);

        repeat (20) @(negedge clk);
        check("R5 idle holds a", int'(seg), 1);

        // long press starts once (R7), clockwise slow
        dir_cw = 1'b1; speed_fast = 1'b0;
        press(25);
        measure(n);
        check("R4 slow period", n, TICK);
        repeat (120) @(negedge clk);
        measure(n);
        check("R5/R7 still running after long press", n, TICK);
        check("R8 rotations counted", int'(rotations), m_rot);

        // speed and direction change while running (R10)
        speed_fast = 1'b1;
        measure(n);
        measure(n);
        check("R4/R10 fast period", n, TICK / 2);
        dir_cw = 1'b0;
        repeat (60) @(negedge clk);
        check("R3/R10 running counterclockwise", m_state, 1);

        // stop with a second edge inside the drain (R6, R11)
        press(1);
        check("R6 stop pending", m_state == 0 ? 1 : m_state, m_state == 0 ? 1 : 2);
        press(1);
        wait_idle();
        @(negedge clk);
        check("R6 landed on a", int'(seg), 1);
        repeat (40) @(negedge clk);
        check("R6/R11 stays idle", int'(seg), 1);

        // clockwise slow, stop right after start
        dir_cw = 1'b1; speed_fast = 1'b0;
        press(1);
        repeat (3) @(negedge clk);
        press(2);
        wait_idle();
        repeat (10) @(negedge clk);
        check("R6 full lap before idle", int'(seg), 1);
        check("R8 lap counted", int'(rotations), m_rot);

        // reset in mid-run (R1)
        press(1);
        repeat (30) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 mid-run reset seg", int'(seg), 1);
        check("R1 mid-run reset rotations", int'(rotations), 0);
        repeat (20) @(negedge clk);
        check("R1/R5 idle after reset", int'(seg), 1);

        finish_sim();
    end
endmodule